// File: doc/BRIEF.md
# Sequential Sign-Magnitude Fixed-Point Divider

This block divides one signed-magnitude fixed-point number by another over a fixed number of clock cycles. Each operand and the quotient use the same layout with `N` total bits. The top bit is the sign, the low `N-1` bits are the magnitude, and the lowest `Q` of those are fractional. The divider works on magnitudes only. It produces one quotient bit per rising edge with a restoring shift-and-subtract loop, and it attaches the sign at the end.

A caller waits for `done_o`, presents the operands and raises `go_i`. The edge that samples `go_i` while `done_o` is high accepts the operation. The quotient and its overflow flag appear together with `done_o` a fixed number of edges later, whatever the operand values. Only one division runs at a time, and `go_i` has no effect while one is in progress. The result is truncated, never rounded. The overflow flag reports a quotient whose magnitude needs more than `N-1` bits, and it also reports a zero divisor.

Top module: `sm_fixdiv`

## Requirements
- R1: The quotient magnitude `quo_o[N-2:0]` equals the low `N-1` bits of floor(|dividend| * 2^Q / |divisor|), where each magnitude is the operand's bits `[N-2:0]`.
- R2: The quotient sign `quo_o[N-1]` is the XOR of `dvd_i[N-1]` and `dvs_i[N-1]`, including when the magnitude is zero.
- R3: `ovf_o` is 1 exactly when the divisor magnitude is nonzero and floor(|dividend| * 2^Q / |divisor|) >= 2^(N-1); otherwise it is 0.
- R4: A divisor magnitude of zero gives `ovf_o` = 1 and `quo_o[N-2:0]` all ones, with the sign following R2.
- R5: An operation is accepted only at a rising edge where `go_i` is 1 and `done_o` is 1; the operands are sampled at that edge and `done_o` is 0 right after it.
- R6: Counting the accepting edge as edge 1, `done_o`, `quo_o` and `ovf_o` take the new result at edge N+Q+1, for every operand value.
- R7: While `done_o` is 0, `go_i` and any change of `dvd_i` or `dvs_i` have no effect on the result or on the completion edge.
- R8: While `done_o` is 1 and no operation is accepted, `done_o` stays 1 and `quo_o` and `ovf_o` keep their values.
- R9: After reset, `done_o` is 1, `ovf_o` is 0 and `quo_o` is 0.
- R10: With `go_i` held at 1, `done_o` is high for exactly one cycle between two operations. During that cycle the first result is visible, and the next operation is accepted at the end of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dvd_i | input | N | Dividend, sign-magnitude with Q fractional bits |
| dvs_i | input | N | Divisor, same layout |
| go_i | input | 1 | Request to start a division |
| quo_o | output | N | Quotient, same layout as the operands |
| done_o | output | 1 | High when the quotient is valid and a new operation can be accepted |
| ovf_o | output | 1 | Quotient magnitude not representable, or divisor zero |

## Verification
The acceptance of a new division and the presentation of the previous result can coincide. When `go_i` stays high, the cycle in which `done_o` rises is also the cycle whose closing edge starts the next division. The bench provokes this by holding `go_i` high across two operations and changing the operands while the first one runs. It then judges three things: the first quotient is visible in that single high cycle of `done_o`, `done_o` is low in the following cycle, and the second quotient arrives exactly N+Q+1 edges after its own acceptance.

// File: rtl/sm_fixdiv_pkg.sv
package sm_fixdiv_pkg;

  // Sequencer phases of the divider.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,   // result valid, ready to accept
    PH_RUN  = 2'd1,   // one quotient bit per edge
    PH_FIN  = 2'd2    // pack result into output registers
  } phase_t;

  // Sign of a quotient from the two operand signs.
  function automatic logic quo_sign(input logic sa, input logic sb);
    return sa ^ sb;
  endfunction

endpackage

// File: rtl/sm_fixdiv_ctrl.sv
module sm_fixdiv_ctrl
  import sm_fixdiv_pkg::*;
#(
  parameter int STEPS = 46
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic accept,
  output logic step_en,
  output logic fin_en,
  output logic done
);

  localparam int CW = $clog2(STEPS + 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic          last_step;

  assign done      = (phase_q == PH_IDLE);
  assign accept    = done && go;
  assign step_en   = (phase_q == PH_RUN);
  assign fin_en    = (phase_q == PH_FIN);
  assign last_step = step_en && (cnt_q == CW'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (go) begin
          phase_q <= PH_RUN;
          cnt_q   <= '0;
        end
        PH_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_step) phase_q <= PH_FIN;
        end
        PH_FIN:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sm_fixdiv_core.sv
module sm_fixdiv_core #(
  parameter int N = 32,
  parameter int Q = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [N-2:0]      a_mag,
  input  logic [N-2:0]      b_mag,
  output logic [N+Q-2:0]    q_full,
  output logic              b_zero
);

  localparam int M  = N - 1;      // magnitude width
  localparam int QW = M + Q;      // width of the extended dividend / raw quotient

  logic [M-1:0]  rem_q;
  logic [QW-1:0] acc_q;   // dividend bits leave at the top, quotient bits enter at the bottom
  logic [M-1:0]  div_q;

  // One restoring step: bring in a bit, subtract if it fits.
  // Returns {quotient bit, new partial remainder}.
  function automatic logic [M:0] trial(input logic [M-1:0] r,
                                       input logic          nb,
                                       input logic [M-1:0]  d);
    logic [M:0] shifted;
    logic [M:0] diff;
    shifted = {r, nb};
    diff    = shifted - {1'b0, d};
    if (shifted >= {1'b0, d}) return {1'b1, diff[M-1:0]};
    else                      return {1'b0, shifted[M-1:0]};
  endfunction

  logic [M:0] nxt;
  assign nxt = trial(rem_q, acc_q[QW-1], div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      acc_q <= '0;
      div_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      acc_q <= {a_mag, {Q{1'b0}}};
      div_q <= b_mag;
    end else if (step) begin
      rem_q <= nxt[M-1:0];
      acc_q <= {acc_q[QW-2:0], nxt[M]};
    end
  end

  assign q_full = acc_q;
  assign b_zero = (div_q == '0);

endmodule

// File: rtl/sm_fixdiv_pack.sv
module sm_fixdiv_pack #(
  parameter int N = 32,
  parameter int Q = 15
) (
  input  logic [N+Q-2:0] q_full,
  input  logic           b_zero,
  input  logic           sign,
  output logic [N-1:0]   quo,
  output logic           ovf
);

  localparam int M = N - 1;

  // Raw quotient does not fit the magnitude field.
  function automatic logic too_wide(input logic [M+Q-1:0] q);
    return |q[M+Q-1:M];
  endfunction

  // Magnitude after overflow / zero-divisor handling.
  function automatic logic [M-1:0] mag_of(input logic [M+Q-1:0] q, input logic z);
    return z ? {M{1'b1}} : q[M-1:0];
  endfunction

  assign ovf = b_zero | too_wide(q_full);
  assign quo = {sign, mag_of(q_full, b_zero)};

endmodule

// File: rtl/sm_fixdiv.sv
module sm_fixdiv
  import sm_fixdiv_pkg::*;
#(
  parameter int N = 32,
  parameter int Q = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] dvd_i,
  input  logic [N-1:0] dvs_i,
  input  logic         go_i,
  output logic [N-1:0] quo_o,
  output logic         done_o,
  output logic         ovf_o
);

  localparam int STEPS = N + Q - 1;   // one per raw quotient bit

  // Named internal events, visible to the checker.
  logic           accept;
  logic           step_en;
  logic           fin_en;
  logic [N+Q-2:0] q_full;
  logic           b_zero;
  logic           sign_q;
  logic [N-1:0]   quo_nxt;
  logic           ovf_nxt;

  sm_fixdiv_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go_i),
    .accept  (accept),
    .step_en (step_en),
    .fin_en  (fin_en),
    .done    (done_o)
  );

  sm_fixdiv_core #(.N(N), .Q(Q)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .step   (step_en),
    .a_mag  (dvd_i[N-2:0]),
    .b_mag  (dvs_i[N-2:0]),
    .q_full (q_full),
    .b_zero (b_zero)
  );

  sm_fixdiv_pack #(.N(N), .Q(Q)) u_pack (
    .q_full (q_full),
    .b_zero (b_zero),
    .sign   (sign_q),
    .quo    (quo_nxt),
    .ovf    (ovf_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
      quo_o  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (accept) sign_q <= quo_sign(dvd_i[N-1], dvs_i[N-1]);
      if (fin_en) begin
        quo_o <= quo_nxt;
        ovf_o <= ovf_nxt;
      end
    end
  end

endmodule

// File: rtl/sm_fixdiv_chk.sv
module sm_fixdiv_chk #(
  parameter int N = 32,
  parameter int Q = 15
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] dvd_i,
  input logic [N-1:0] dvs_i,
  input logic         go_i,
  input logic [N-1:0] quo_o,
  input logic         done_o,
  input logic         ovf_o,
  input logic         accept,
  input logic         step_en,
  input logic         fin_en
);

  localparam int LAT = N + Q + 1;
  localparam int CW  = $clog2(LAT + 2);

  logic [CW-1:0] lat_q;
  logic          zdiv_q;
  logic          sgn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      zdiv_q <= 1'b0;
      sgn_q  <= 1'b0;
    end else if (go_i && done_o) begin
      lat_q  <= CW'(1);
      zdiv_q <= (dvs_i[N-2:0] == '0);
      sgn_q  <= dvd_i[N-1] ^ dvs_i[N-1];
    end else if (!done_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R5: done only drops after an accepting edge
  assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_o) |-> $past(go_i));

  // R6: completion lands on edge N+Q+1 counted from acceptance
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (lat_q == CW'(LAT)));

  // R8: idle without a request holds everything
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !go_i) |=> (done_o && $stable(quo_o) && $stable(ovf_o)));

  // R4: zero divisor saturates and flags
  assert_zero_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_o) && zdiv_q) |-> (ovf_o && (&quo_o[N-2:0])));

  // R2: sign of the result
  assert_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (quo_o[N-1] == sgn_q));

  // R7: sequencer events never overlap
  assert_one_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept, step_en, fin_en}));

endmodule

bind sm_fixdiv sm_fixdiv_chk #(.N(N), .Q(Q)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dvd_i   (dvd_i),
  .dvs_i   (dvs_i),
  .go_i    (go_i),
  .quo_o   (quo_o),
  .done_o  (done_o),
  .ovf_o   (ovf_o),
  .accept  (accept),
  .step_en (step_en),
  .fin_en  (fin_en)
);

// File: tb/test_sm_fixdiv.sv
`timescale 1ns/100ps
module test_sm_fixdiv;

  localparam int N   = 32;
  localparam int Q   = 15;
  localparam int LAT = N + Q + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] dvd_i = '0;
  logic [N-1:0] dvs_i = '0;
  logic         go_i = 1'b0;
  logic [N-1:0] quo_o;
  logic         done_o;
  logic         ovf_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sm_fixdiv #(.N(N), .Q(Q)) i_sm_fixdiv (
    .clk(clk), .rst_n(rst_n), .dvd_i(dvd_i), .dvs_i(dvs_i), .go_i(go_i),
    .quo_o(quo_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  // Expected result straight from R1..R4.
  function automatic void model(input logic [N-1:0] a, input logic [N-1:0] b,
                                output logic [N-1:0] q, output logic v);
    longint unsigned ma, mb, full;
    ma = 64'(a[N-2:0]);
    mb = 64'(b[N-2:0]);
    if (mb == 0) begin
      v = 1'b1;
      q = {a[N-1] ^ b[N-1], {(N-1){1'b1}}};
    end else begin
      full = (ma << Q) / mb;
      v = (full >> (N - 1)) != 0;
      q = {a[N-1] ^ b[N-1], full[N-2:0]};
    end
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Wait from an accepting edge to completion; returns edges counted incl. accept.
  task automatic wait_done(output int lat, input bit disturb);
    lat = 1;
    forever begin
      @(negedge clk);
      if (done_o) break;
      lat++;
      if (disturb && lat == 10) begin
        dvd_i = $urandom; dvs_i = $urandom; go_i = 1'b1;   // R7 stimulus
      end else if (disturb && lat == 11) begin
        go_i = 1'b0;
      end
      if (lat > 4 * LAT) break;
    end
  endtask

  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit disturb);
    logic [N-1:0] eq;
    logic ev;
    int lat;
    model(a, b, eq, ev);
    @(negedge clk);
    dvd_i = a; dvs_i = b; go_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go_i = 1'b0;
    check(done_o == 1'b0, "R5", 64'(done_o), 64'(0));
    lat = 1;
    if (!done_o) wait_done(lat, disturb);
    else lat = 1;
    lat = lat + 1;
    check(lat == LAT, disturb ? "R7" : "R6", 64'(lat), 64'(LAT));
    check(quo_o[N-2:0] == eq[N-2:0], b[N-2:0] == 0 ? "R4" : "R1", 64'(quo_o), 64'(eq));
    check(quo_o[N-1] == eq[N-1], "R2", 64'(quo_o[N-1]), 64'(eq[N-1]));
    check(ovf_o == ev, "R3", 64'(ovf_o), 64'(ev));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] q0, e1, e2;
    logic v0, ev1, ev2;
    int lat;
    void'($urandom(32'd4099));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(done_o == 1'b1, "R9", 64'(done_o), 64'(1));
    check(ovf_o == 1'b0, "R9", 64'(ovf_o), 64'(0));
    check(quo_o == '0, "R9", 64'(quo_o), 64'(0));
    rst_n = 1'b1;

    // Directed corner cases (magnitude 1.0 = 1<<Q)
    run_op(32'h0001_8000, 32'h0000_C000, 0);   // R1: 3.0 / 1.5 = 2.0
    run_op(32'h8000_8000, 32'h0001_0000, 0);   // R2: -1.0 / 2.0
    run_op(32'h8000_0000, 32'h0000_8000, 0);   // R2: negative zero dividend
    run_op(32'h0001_0000, 32'h0000_0000, 0);   // R4: zero divisor
    run_op(32'h8000_0000, 32'h8000_0000, 0);   // R4: zero over zero
    run_op(32'h7FFF_FFFF, 32'h0000_0001, 0);   // R3: overflow
    run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0);   // R1: equal -> 1.0
    run_op(32'h0000_0001, 32'h7FFF_FFFF, 0);   // R1: tiny -> 0
    run_op(32'h0000_4000, 32'h0000_8000, 1);   // R7: disturbed mid-run

    // R8: idle hold while inputs wiggle
    q0 = quo_o; v0 = ovf_o;
    for (int i = 0; i < 6; i++) begin
      dvd_i = $urandom; dvs_i = $urandom;
      @(negedge clk);
      check(done_o && quo_o == q0 && ovf_o == v0, "R8", 64'(quo_o), 64'(q0));
    end

    // R10: go held high across two operations
    model(32'h0000_6000, 32'h8000_2000, e1, ev1);
    model(32'h0002_0000, 32'h0000_4000, e2, ev2);
    dvd_i = 32'h0000_6000; dvs_i = 32'h8000_2000; go_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dvd_i = 32'h0002_0000; dvs_i = 32'h0000_4000;
    wait_done(lat, 0);
    lat++;
    check(lat == LAT, "R10", 64'(lat), 64'(LAT));
    check(quo_o == e1 && ovf_o == ev1, "R10", 64'(quo_o), 64'(e1));
    @(negedge clk);
    check(done_o == 1'b0, "R10", 64'(done_o), 64'(0));
    go_i = 1'b0;
    wait_done(lat, 0);
    lat = lat + 1;
    check(lat == LAT, "R10", 64'(lat), 64'(LAT));
    check(quo_o == e2 && ovf_o == ev2, "R10", 64'(quo_o), 64'(e2));

    // Constrained random: mixed ranges so both fitting and overflowing quotients occur
    for (int k = 0; k < 150; k++) begin
      logic [N-1:0] a, b;
      a = $urandom;
      b = $urandom;
      unique case (k % 4)
        0: a[N-2:0] = a[N-2:0] >> ($urandom % 24);
        1: b[N-2:0] = b[N-2:0] >> ($urandom % 28);
        2: b[N-2:0] = (k % 8 == 2) ? '0 : b[N-2:0];
        default: ;
      endcase
      run_op(a, b, (k % 10) == 5);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule